// File: doc/BRIEF.md
# Serial-to-Parallel Output Expander

This block turns a 24-bit output image into a serial stream for a chain of external 8-bit shift registers, so that a few pins provide many extra outputs. Software writes the image, a group-present mask, the shift clock polarity and a set of per-bit hardware ownership enables through a simple register port. Any output bit owned by hardware follows a live status input (a 2-bit DSL status and two 3-bit PHY status buses) instead of the software value.

Whenever the composed image (software bits merged with hardware-owned bits) differs from the image last sent, the block shifts out the enabled groups and then raises a store strobe so all external registers update together. The shift clock is derived from the system clock by a half-period divider. The register port takes a write in any cycle and never stalls. A write that arrives during a transfer changes the image at once and goes out in the following transfer. No stream handshake exists, so there is no back-pressure.

Register map: address 0 holds the image, address 1 holds configuration (bits [2:0] group mask, bit 3 rising-edge select), address 2 holds the ownership enables (bits [1:0] DSL, bits [4:2] PHY A, bits [7:5] PHY B). Address 3 reads as zero.

Top module: `stp_shift_drv`

## Requirements
- R1: After reset busy, sh_store and sh_data are 0, sh_clk rests high (falling-edge default), address 0 reads INIT_IMAGE, address 1 reads the reset mask 3'b111 with bit 3 clear, and no transfer starts because the initial image counts as already sent.
- R2: A write to address 0 that changes the composed image makes busy high in the cycle after the write's clock edge.
- R3: The highest-numbered enabled group is shifted first and each group goes MSB first, so image bit 0 is the last bit shifted.
- R4: Only groups whose mask bit (address 1, bits [2:0]) is set are shifted, giving exactly 8 active edges per enabled group. With mask 0 no transfer runs; a pending change is sent once a mask bit is set.
- R5: Address 1 bit 3 set makes the rising edge active with the clock resting low; clear makes the falling edge active with the clock resting high. sh_data changes only at the inactive edge, half a shift period before the active edge.
- R6: After the last bit, sh_store is high for one shift period (2*HALF_DIV cycles) with sh_clk at rest, and busy lasts exactly (8n+1)*2*HALF_DIV cycles for n enabled groups.
- R7: Enable bits [1:0] at address 2 make image bits 0 and 1 follow dsl_in[0] and dsl_in[1].
- R8: Enable bits [4:2] make image bits 2..4 follow phy_a_in[2:0]; enable bits [7:5] make bits 5..7 follow phy_b_in[2:0].
- R9: A hardware-owned bit ignores software writes; address 0 returns the live composed value; releasing ownership restores the software value held before ownership.
- R10: A change on an owned hardware input starts a transfer in the cycle after the change is sampled.
- R11: A write during a transfer is sent in the next transfer; a write that leaves the composed image equal to the last sent image starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 24 | Read data, combinational |
| dsl_in | input | 2 | DSL status bits for image bits 0..1 |
| phy_a_in | input | 3 | First PHY status bits for image bits 2..4 |
| phy_b_in | input | 3 | Second PHY status bits for image bits 5..7 |
| busy | output | 1 | Transfer in progress |
| sh_clk | output | 1 | Shift clock to the register chain |
| sh_data | output | 1 | Serial data to the register chain |
| sh_store | output | 1 | Store strobe to the register chain |

## Verification
Busy is due one clock after the edge that registers a write or samples a changed hardware input; the bench drives on the falling system clock edge and samples busy on the very next falling edge. The serial result is due only when sh_store rises, after 8n active shift edges, so a behavioural model of the external chain shifts on each observed active edge and latches on the strobe, making the data checks independent of divider length. Transfer length is checked as an exact count of (8n+1)*2*HALF_DIV busy cycles, and data stability is checked on the sample just before each active edge.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int DSL_W = 2;
  localparam int PHY_W = 3;
  localparam int HW_W  = DSL_W + 2 * PHY_W;

  localparam logic [1:0] ADDR_IMG  = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_HWEN = 2'd2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_STORE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/stp_regs.sv
module stp_regs
  import stp_pkg::*;
#(
  parameter int GROUPS = 3,
  parameter int GRP_W  = 8,
  parameter logic [GROUPS*GRP_W-1:0] INIT_IMAGE = '1,
  parameter logic [GROUPS-1:0] INIT_MASK = '1,
  parameter bit INIT_RISE = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [GROUPS*GRP_W-1:0]   wr_data,
  input  logic [1:0]                rd_addr,
  output logic [GROUPS*GRP_W-1:0]   rd_data,
  input  logic [DSL_W-1:0]          dsl_in,
  input  logic [PHY_W-1:0]          phy_a_in,
  input  logic [PHY_W-1:0]          phy_b_in,
  output logic [GROUPS*GRP_W-1:0]   image,
  output logic [GROUPS-1:0]         mask,
  output logic                      rise
);
  localparam int IMG_W = GROUPS * GRP_W;

  logic [IMG_W-1:0] sw_q;
  logic [HW_W-1:0]  hwen_q;
  logic [IMG_W-1:0] hw_own;
  logic [IMG_W-1:0] hw_val;

  assign hw_own = IMG_W'(hwen_q);
  assign hw_val = IMG_W'({phy_b_in, phy_a_in, dsl_in});
  assign image  = (sw_q & ~hw_own) | (hw_val & hw_own);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q   <= INIT_IMAGE;
      mask   <= INIT_MASK;
      rise   <= INIT_RISE;
      hwen_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_IMG:  sw_q <= (wr_data & ~hw_own) | (sw_q & hw_own);
        ADDR_CFG:  begin
          mask <= wr_data[GROUPS-1:0];
          rise <= wr_data[GROUPS];
        end
        ADDR_HWEN: hwen_q <= wr_data[HW_W-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_IMG:  rd_data = image;
      ADDR_CFG:  rd_data = IMG_W'({rise, mask});
      ADDR_HWEN: rd_data = IMG_W'(hwen_q);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/stp_divider.sv
module stp_divider #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stp_seq.sv
module stp_seq
  import stp_pkg::*;
#(
  parameter int GROUPS = 3,
  parameter int GRP_W  = 8,
  parameter logic [GROUPS*GRP_W-1:0] INIT_IMAGE = '1,
  parameter bit INIT_RISE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GROUPS*GRP_W-1:0] image,
  input  logic [GROUPS-1:0]       mask,
  input  logic                    rise,
  input  logic                    tick,
  output logic                    run,
  output logic                    sh_clk,
  output logic                    sh_data,
  output logic                    sh_store
);
  localparam int IMG_W = GROUPS * GRP_W;
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int BW = (GRP_W > 1) ? $clog2(GRP_W) : 1;
  localparam int IW = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam logic [BW-1:0] TOP_BIT = BW'(GRP_W - 1);

  seq_state_e       st;
  logic [IMG_W-1:0] snap, sent;
  logic [GROUPS-1:0] mask_l;
  logic [GW-1:0]    grp, top_g, nxt_g;
  logic [BW-1:0]    bitn;
  logic             phase, has_nxt, edge_l, start;
  logic [IW-1:0]    idx;

  assign start = (image != sent) && (|mask);
  assign run   = (st != SEQ_IDLE);
  assign idx   = IW'(grp) * IW'(GRP_W) + IW'(bitn);

  always_comb begin
    top_g = '0;
    for (int g = 0; g < GROUPS; g++)
      if (mask[g]) top_g = GW'(g);
  end

  always_comb begin
    nxt_g   = '0;
    has_nxt = 1'b0;
    for (int g = 0; g < GROUPS; g++) begin
      if (mask_l[g] && (GW'(g) < grp)) begin
        nxt_g   = GW'(g);
        has_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SEQ_IDLE;
      snap   <= INIT_IMAGE;
      sent   <= INIT_IMAGE;
      mask_l <= '0;
      grp    <= '0;
      bitn   <= '0;
      phase  <= 1'b0;
      edge_l <= INIT_RISE;
    end else begin
      case (st)
        SEQ_IDLE: begin
          edge_l <= rise;
          if (start) begin
            snap   <= image;
            sent   <= image;
            mask_l <= mask;
            grp    <= top_g;
            bitn   <= TOP_BIT;
            phase  <= 1'b0;
            st     <= SEQ_SHIFT;
          end
        end
        SEQ_SHIFT: if (tick) begin
          phase <= ~phase;
          if (phase) begin
            if (bitn != '0) bitn <= bitn - 1'b1;
            else if (has_nxt) begin
              grp  <= nxt_g;
              bitn <= TOP_BIT;
            end else st <= SEQ_STORE;
          end
        end
        SEQ_STORE: if (tick) begin
          phase <= ~phase;
          if (phase) st <= SEQ_IDLE;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assign sh_clk   = (st == SEQ_SHIFT && phase) ? edge_l : ~edge_l;
  assign sh_data  = (st == SEQ_SHIFT) ? snap[idx] : 1'b0;
  assign sh_store = (st == SEQ_STORE);
endmodule

// File: rtl/stp_shift_drv.sv
module stp_shift_drv
  import stp_pkg::*;
#(
  parameter int GROUPS   = 3,
  parameter int GRP_W    = 8,
  parameter int HALF_DIV = 4,
  parameter logic [GROUPS*GRP_W-1:0] INIT_IMAGE = 24'h00FFFF,
  parameter logic [GROUPS-1:0] INIT_MASK = '1,
  parameter bit INIT_RISE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [GROUPS*GRP_W-1:0] wr_data,
  input  logic [1:0]              rd_addr,
  output logic [GROUPS*GRP_W-1:0] rd_data,
  input  logic [DSL_W-1:0]        dsl_in,
  input  logic [PHY_W-1:0]        phy_a_in,
  input  logic [PHY_W-1:0]        phy_b_in,
  output logic                    busy,
  output logic                    sh_clk,
  output logic                    sh_data,
  output logic                    sh_store
);
  localparam int IMG_W = GROUPS * GRP_W;

  logic [IMG_W-1:0]  image;
  logic [GROUPS-1:0] mask;
  logic              rise, tick, run;

  stp_regs #(
    .GROUPS(GROUPS), .GRP_W(GRP_W), .INIT_IMAGE(INIT_IMAGE),
    .INIT_MASK(INIT_MASK), .INIT_RISE(INIT_RISE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dsl_in(dsl_in), .phy_a_in(phy_a_in), .phy_b_in(phy_b_in),
    .image(image), .mask(mask), .rise(rise)
  );

  stp_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  stp_seq #(
    .GROUPS(GROUPS), .GRP_W(GRP_W), .INIT_IMAGE(INIT_IMAGE), .INIT_RISE(INIT_RISE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .image(image), .mask(mask), .rise(rise),
    .tick(tick), .run(run), .sh_clk(sh_clk), .sh_data(sh_data),
    .sh_store(sh_store)
  );

  assign busy = run;
endmodule

// File: rtl/stp_shift_drv_chk.sv
module stp_shift_drv_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sh_clk,
  input logic sh_data,
  input logic sh_store
);
  logic busy_q, idle_q, cur_idle;
  int   store_len;

  assign cur_idle = (busy && !busy_q) ? sh_clk : idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      idle_q    <= 1'b0;
      store_len <= 0;
    end else begin
      busy_q    <= busy;
      idle_q    <= cur_idle;
      store_len <= sh_store ? store_len + 1 : 0;
    end
  end

  // R6
  store_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_store |-> busy);

  // R6
  store_clk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_store |-> (sh_clk == cur_idle));

  // R6
  store_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_store) |-> (store_len == 2 * HALF_DIV));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sh_store));

  // R5
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (sh_clk != cur_idle) && ($past(sh_clk) == cur_idle))
      |-> $stable(sh_data));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sh_store && !sh_data));
endmodule

bind stp_shift_drv stp_shift_drv_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sh_clk(sh_clk),
  .sh_data(sh_data), .sh_store(sh_store)
);

// File: tb/stp_shift_drv_test.sv
module stp_shift_drv_test;
  localparam int HALF = 2;
  localparam logic [23:0] INIT_IMG = 24'h00FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [23:0] rd_data;
  logic [1:0]  dsl_in = '0;
  logic [2:0]  phy_a_in = '0;
  logic [2:0]  phy_b_in = '0;
  logic        busy, sh_clk, sh_data, sh_store;

  stp_shift_drv #(.HALF_DIV(HALF), .INIT_IMAGE(INIT_IMG)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dsl_in(dsl_in), .phy_a_in(phy_a_in), .phy_b_in(phy_b_in),
    .busy(busy), .sh_clk(sh_clk), .sh_data(sh_data), .sh_store(sh_store)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // external chain model
  bit          b_rise = 0;
  logic [23:0] ext_sr = '0, ext_out = '0;
  logic        prev_clk = 1'b1, prev_data = 1'b0, prev_store = 1'b0;
  int          edge_cnt = 0, busy_cyc = 0, stab_err = 0;

  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (busy && sh_clk != prev_clk && sh_clk == b_rise) begin
      ext_sr = {ext_sr[22:0], sh_data};
      edge_cnt++;
      if (sh_data != prev_data) stab_err++;
    end
    if (sh_store && !prev_store) ext_out = ext_sr;
    prev_clk = sh_clk; prev_data = sh_data; prev_store = sh_store;
  end

  // bench model of the register state
  logic [23:0] sw_m = INIT_IMG;
  logic [7:0]  en_m = '0;

  function automatic logic [23:0] comp_m();
    logic [23:0] own = {16'h0, en_m};
    logic [23:0] hv  = {16'h0, phy_b_in, phy_a_in, dsl_in};
    return (sw_m & ~own) | (hv & own);
  endfunction

  function automatic logic [23:0] pack(input logic [23:0] img, input logic [2:0] m);
    logic [23:0] r = '0;
    for (int g = 2; g >= 0; g--)
      if (m[g]) r = (r << 8) | {16'h0, img[g*8 +: 8]};
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    if (a == 2'd0) sw_m = (d & ~{16'h0, en_m}) | (sw_m & {16'h0, en_m});
    if (a == 2'd2) en_m = d[7:0];
    if (a == 2'd1) b_rise = d[3];
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [23:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic run_xfer(input logic [23:0] img, input logic [2:0] m, input bit cnt_chk, input string tag);
    int e0 = edge_cnt, b0 = busy_cyc, n = $countones(m), w = 0;
    logic [23:0] lm = (n == 3) ? 24'hFFFFFF : ((24'h1 << (8 * n)) - 24'h1);
    while (!busy && w < 6) begin step(); w++; end
    chk(busy, {tag, " start"}, 32'(busy), 1);
    while (busy) step();
    chk((ext_out & lm) == pack(img, m), {tag, " R3 serial image"}, 32'(ext_out & lm), 32'(pack(img, m)));
    if (cnt_chk) begin
      chk(edge_cnt - e0 == 8 * n, {tag, " R4 edge count"}, 32'(edge_cnt - e0), 32'(8 * n));
      chk(busy_cyc - b0 == (8 * n + 1) * 2 * HALF, {tag, " R6 busy length"},
          32'(busy_cyc - b0), 32'((8 * n + 1) * 2 * HALF));
    end
  endtask

  task automatic quiet(input int cyc, input string tag);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin step(); if (busy) seen = 1; end
    chk(!seen, tag, 32'(seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [23:0] d, img, prev, c;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(busy == 0 && sh_store == 0 && sh_data == 0, "R1 idle outputs", {busy, sh_store, sh_data}, 0);
    chk(sh_clk == 1, "R1 clock rest level", 32'(sh_clk), 1);
    rd(2'd0, d); chk(d == INIT_IMG, "R1 image reset", d, INIT_IMG);
    rd(2'd1, d); chk(d == 24'h7, "R1 config reset", d, 24'h7);
    quiet(10, "R1 no transfer at start");

    // R2 busy timing after a write
    wr(2'd0, 24'hA5C381);
    chk(busy == 0, "R2 busy before start", 32'(busy), 0);
    step();
    chk(busy == 1, "R2 busy one cycle after write", 32'(busy), 1);
    run_xfer(24'hA5C381, 3'b111, 0, "R2");

    // R3 R4 R5 R6 sweep of masks and edges
    for (int r = 0; r < 2; r++) begin
      for (int m = 1; m < 8; m++) begin
        wr(2'd1, 24'((r << 3) | m));
        step(); step();
        chk(sh_clk == !r[0], "R5 rest level", 32'(sh_clk), 32'(!r[0]));
        img = 24'h5A3C96 ^ (24'(m) * 24'h010101) ^ (r ? 24'hFFFFFF : 24'h0);
        wr(2'd0, img);
        run_xfer(img, 3'(m), 1, "R4 sweep");
        chk(sh_clk == !r[0], "R5 rest after transfer", 32'(sh_clk), 32'(!r[0]));
      end
    end
    chk(stab_err == 0, "R5 data stable at active edge", stab_err, 0);

    // R4 mask zero holds the change
    wr(2'd1, 24'h0);
    wr(2'd0, 24'h13579B);
    quiet(20, "R4 mask zero no transfer");
    wr(2'd1, 24'h7);
    run_xfer(24'h13579B, 3'b111, 1, "R4 mask reenabled");

    // R7 R8 R9 ownership sweep
    wr(2'd0, 24'h0F0F0F);
    run_xfer(24'h0F0F0F, 3'b111, 0, "R9 base");
    dsl_in = 2'b10; phy_a_in = 3'b101; phy_b_in = 3'b011;
    quiet(6, "R9 unowned inputs ignored");
    prev = 24'h0F0F0F;
    for (int e = 0; e < 256; e++) begin
      wr(2'd2, 24'(e));
      c = comp_m();
      rd(2'd0, d);
      chk(d == c, "R9 live read-back", d, c);
      rd(2'd2, d);
      chk(d[7:0] == 8'(e), "R9 enable read-back", d, 24'(e));
      if (c != prev) run_xfer(c, 3'b111, 0, e[7:2] != 0 ? "R8 phy owned" : "R7 dsl owned");
      else quiet(4, "R7 R8 no change no transfer");
      prev = c;
    end

    // R9 owned bits ignore writes, restore on release
    wr(2'd2, 24'hFF);
    wr(2'd0, 24'hABCD00);
    run_xfer(24'hABCD76, 3'b111, 0, "R9 write masked");
    wr(2'd2, 24'h00);
    run_xfer(24'hABCD0F, 3'b111, 0, "R9 release restores");

    // R10 hardware change triggers
    wr(2'd2, 24'h03);
    run_xfer(comp_m(), 3'b111, 0, "R10 enable");
    dsl_in = 2'b01;
    step();
    chk(busy == 1, "R10 busy after input change", 32'(busy), 1);
    run_xfer(24'hABCD0D, 3'b111, 0, "R10 dsl change");

    // R11 write during transfer is held
    wr(2'd0, 24'h111111);
    step();
    chk(busy == 1, "R11 first busy", 32'(busy), 1);
    repeat (10) step();
    wr(2'd0, 24'h2222EE);
    chk(busy == 1, "R11 write landed mid transfer", 32'(busy), 1);
    run_xfer(24'h111111 & 24'hFFFFFC | 24'h1, 3'b111, 0, "R11 first image");
    run_xfer(comp_m(), 3'b111, 0, "R11 held image");
    wr(2'd0, 24'h2222EE);
    quiet(12, "R11 equal write no transfer");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule